// File: doc/BRIEF.md
# Thermal Threshold Interrupt Unit

This unit watches the sensor codes published for each thermal channel. It compares each new code against two limits held in registers. The first is an alarm limit, which has a separate release level. The second is a shutdown limit. A hotter die gives a smaller code, so a limit is crossed when the code falls to or below it. Each channel has a two-state machine with the states `CH_NORMAL` and `CH_HOT`. The transition *arm* moves a channel from `CH_NORMAL` to `CH_HOT` when a new code is at or below the alarm limit, and this raises one alarm event. The transition *release* moves it from `CH_HOT` back to `CH_NORMAL` when a new code is strictly above the release level. While a channel is in `CH_HOT`, no further alarm events are raised.

Three kinds of event set sticky status flags: alarm, shutdown and new-data. Software clears a flag by writing a one to it. A single interrupt line is high while any flag and its matching enable are both set. Writes use a one-cycle write strobe. Reads come from a separate combinational read address.

Top module: `thermal_irq_unit`

## Requirements
- R1: After reset the status and enable registers read 0, every threshold register reads 0, and `irq` is low.
- R2: A valid sample whose code is less than or equal to the channel's hot code sets alarm flag bit ch of the status word (at offset 0x48), provided the channel is in `CH_NORMAL`.
- R3: While a channel is in `CH_HOT`, samples do not set its alarm flag. A sample equal to the release code keeps the channel in `CH_HOT`. A sample strictly above the release code returns it to `CH_NORMAL`, and after that the alarm can fire again.
- R4: A valid sample whose code is less than or equal to the shutdown code sets status bit 4+ch. This happens on every such sample, whatever the alarm state.
- R5: Every valid sample sets status bit 8+ch (the new-data flag).
- R6: A write to offset 0x48 clears every status bit written as one and leaves bits written as zero unchanged.
- R7: A status bit that is set by an event in the same cycle as a clear write to it stays set.
- R8: `irq` is high exactly when some status bit and the enable bit at the same position of the enable register (offset 0x44) are both set.
- R9: The per-channel alarm register sits at offset 0x50+4*ch, with the hot code in bits [27:16] and the release code in bits [11:0]. The per-channel shutdown register sits at offset 0x60+4*ch, with its code in bits [27:16]. All other bits of these registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| smp_valid | input | NCH | One-cycle strobe per channel: a new code is present |
| smp_code | input | NCH*CODE_W | Packed sensor codes, channel 0 in the low bits |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write byte offset |
| wr_data | input | 32 | Write data |
| rd_addr | input | ADDR_W | Read byte offset |
| rd_data | output | 32 | Read data for rd_addr (combinational) |
| irq | output | 1 | Interrupt request |

## Verification
The bench uses the default build: three channels, 12-bit codes and 8-bit offsets. This fills every flag group, so a partial clear and an unenabled flag on a second channel can be observed together with the first channel's state. Several corner cases are driven on purpose:
- codes exactly at the hot level;
- codes exactly at the release level;
- codes exactly at the shutdown level;
- a clear write landing in the same cycle as a new event.

// File: rtl/thermal_irq_pkg.sv
package thermal_irq_pkg;
    typedef enum logic {
        CH_NORMAL = 1'b0,
        CH_HOT    = 1'b1
    } ch_state_t;

    localparam int OFF_IEN    = 'h44;
    localparam int OFF_STATUS = 'h48;
    localparam int OFF_ALARM  = 'h50;
    localparam int OFF_SHUT   = 'h60;
    localparam int HI_LSB     = 16;
    localparam int SHUT_GRP   = 4;
    localparam int DATA_GRP   = 8;
endpackage

// File: rtl/thermal_chan_fsm.sv
module thermal_chan_fsm
    import thermal_irq_pkg::*;
#(
    parameter int CODE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid,
    input  logic [CODE_W-1:0] code,
    input  logic [CODE_W-1:0] hot_code,
    input  logic [CODE_W-1:0] rel_code,
    input  logic [CODE_W-1:0] shut_code,
    output logic              alarm_evt,
    output logic              shut_evt,
    output logic              data_evt
);
    ch_state_t state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_NORMAL;
        else        state_q <= state_d;
    end

    // next state and event outputs
    always_comb begin
        state_d   = state_q;
        alarm_evt = 1'b0;
        shut_evt  = valid && (code <= shut_code);
        data_evt  = valid;
        unique case (state_q)
            CH_NORMAL: begin
                if (valid && (code <= hot_code)) begin
                    alarm_evt = 1'b1;
                    state_d   = CH_HOT;
                end
            end
            CH_HOT: begin
                if (valid && (code > rel_code)) state_d = CH_NORMAL;
            end
            default: state_d = CH_NORMAL;
        endcase
    end

    p_arm_enters_hot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_evt |=> (state_q == CH_HOT));

    p_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_HOT && valid && code > rel_code) |=> (state_q == CH_NORMAL));

    p_hold_hot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_HOT && !(valid && code > rel_code)) |=> (state_q == CH_HOT));
endmodule

// File: rtl/thermal_status_reg.sv
module thermal_status_reg #(
    parameter int NF = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NF-1:0] set_v,
    input  logic [NF-1:0] clr_v,
    output logic [NF-1:0] stat_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (stat_q & ~clr_v) | set_v;
    end

    p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (set_v != '0) |=> ((stat_q & $past(set_v)) == $past(set_v)));

    p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_v != '0) |=> ((stat_q & $past(clr_v & ~set_v)) == '0));
endmodule

// File: rtl/thermal_irq_unit.sv
module thermal_irq_unit
    import thermal_irq_pkg::*;
#(
    parameter int NCH    = 3,
    parameter int CODE_W = 12,
    parameter int ADDR_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NCH-1:0]        smp_valid,
    input  logic [NCH*CODE_W-1:0] smp_code,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [31:0]           wr_data,
    input  logic [ADDR_W-1:0]     rd_addr,
    output logic [31:0]           rd_data,
    output logic                  irq
);
    localparam int NF = 3 * NCH;

    logic [NCH-1:0][CODE_W-1:0] hot_q, rel_q, shut_q;
    logic [NF-1:0] en_q, stat_q, set_v, clr_v;
    logic [NCH-1:0] a_evt, s_evt, d_evt;

    function automatic logic [31:0] pack_w(input logic [NF-1:0] v);
        logic [31:0] w;
        w = '0;
        for (int i = 0; i < NCH; i++) begin
            w[i]            = v[i];
            w[SHUT_GRP + i] = v[NCH + i];
            w[DATA_GRP + i] = v[2*NCH + i];
        end
        return w;
    endfunction

    function automatic logic [NF-1:0] unpack_w(input logic [31:0] w);
        logic [NF-1:0] v;
        for (int i = 0; i < NCH; i++) begin
            v[i]         = w[i];
            v[NCH + i]   = w[SHUT_GRP + i];
            v[2*NCH + i] = w[DATA_GRP + i];
        end
        return v;
    endfunction

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        localparam logic [ADDR_W-1:0] A_ADDR = ADDR_W'(OFF_ALARM + 4*c);
        localparam logic [ADDR_W-1:0] S_ADDR = ADDR_W'(OFF_SHUT + 4*c);
        logic [CODE_W-1:0] code_c;
        assign code_c = smp_code[c*CODE_W +: CODE_W];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                hot_q[c]  <= '0;
                rel_q[c]  <= '0;
                shut_q[c] <= '0;
            end else if (wr_en) begin
                if (wr_addr == A_ADDR) begin
                    hot_q[c] <= wr_data[HI_LSB +: CODE_W];
                    rel_q[c] <= wr_data[CODE_W-1:0];
                end
                if (wr_addr == S_ADDR) shut_q[c] <= wr_data[HI_LSB +: CODE_W];
            end
        end

        thermal_chan_fsm #(.CODE_W(CODE_W)) u_fsm (
            .clk       (clk),
            .rst_n     (rst_n),
            .valid     (smp_valid[c]),
            .code      (code_c),
            .hot_code  (hot_q[c]),
            .rel_code  (rel_q[c]),
            .shut_code (shut_q[c]),
            .alarm_evt (a_evt[c]),
            .shut_evt  (s_evt[c]),
            .data_evt  (d_evt[c])
        );

        p_shut_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (smp_valid[c] && code_c <= shut_q[c]) |=> stat_q[NCH + c]);

        p_data_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
            smp_valid[c] |=> stat_q[2*NCH + c]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                         en_q <= '0;
        else if (wr_en && wr_addr == ADDR_W'(OFF_IEN))      en_q <= unpack_w(wr_data);
    end

    assign set_v = {d_evt, s_evt, a_evt};
    assign clr_v = (wr_en && wr_addr == ADDR_W'(OFF_STATUS)) ? unpack_w(wr_data) : '0;

    thermal_status_reg #(.NF(NF)) u_stat (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_v  (set_v),
        .clr_v  (clr_v),
        .stat_q (stat_q)
    );

    assign irq = |(stat_q & en_q);

    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_W'(OFF_IEN))    rd_data = pack_w(en_q);
        if (rd_addr == ADDR_W'(OFF_STATUS)) rd_data = pack_w(stat_q);
        for (int i = 0; i < NCH; i++) begin
            if (rd_addr == ADDR_W'(OFF_ALARM + 4*i)) begin
                rd_data[HI_LSB +: CODE_W] = hot_q[i];
                rd_data[CODE_W-1:0]       = rel_q[i];
            end
            if (rd_addr == ADDR_W'(OFF_SHUT + 4*i))
                rd_data[HI_LSB +: CODE_W] = shut_q[i];
        end
    end

    logic unused_bits;
    assign unused_bits = ^wr_data;

    p_irq_rises_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_W'(OFF_IEN) && ((unpack_w(wr_data) & (stat_q | set_v)) != '0))
        |=> irq);
endmodule

// File: tb/thermal_irq_unit_test.sv
module thermal_irq_unit_test;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 3;
    localparam int CW  = 12;
    localparam int AW  = 8;

    logic clk = 0, rst_n = 0;
    logic [NCH-1:0] smp_valid = '0;
    logic [NCH*CW-1:0] smp_code = '0;
    logic wr_en = 0;
    logic [AW-1:0] wr_addr = '0, rd_addr = '0;
    logic [31:0] wr_data = '0, rd_data;
    logic irq;

    int total = 0, bad = 0;
    bit done = 0;

    typedef struct {
        string       req;
        logic [AW-1:0] addr;
        logic [31:0] val;
        logic        irq_e;
    } exp_t;
    exp_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    thermal_irq_unit #(.NCH(NCH), .CODE_W(CW), .ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_code(smp_code),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
    );

    // monitor: pops expected items and compares
    initial begin
        forever begin
            exp_t it;
            wait (exp_q.size() != 0);
            it = exp_q.pop_front();
            rd_addr = it.addr;
            #1;
            total++;
            if (rd_data !== it.val) begin
                bad++;
                $display("FAIL %s addr=%h actual=%h expected=%h", it.req, it.addr, rd_data, it.val);
            end
            total++;
            if (irq !== it.irq_e) begin
                bad++;
                $display("FAIL %s irq actual=%b expected=%b", it.req, irq, it.irq_e);
            end
        end
    end

    task automatic expect_rd(input string req, input logic [AW-1:0] a, input logic [31:0] v, input logic ie);
        exp_t it;
        @(negedge clk);
        it.req = req; it.addr = a; it.val = v; it.irq_e = ie;
        exp_q.push_back(it);
        wait (exp_q.size() == 0);
        #3;
    endtask

    task automatic reg_wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic sample(input int ch, input logic [CW-1:0] code);
        @(negedge clk);
        smp_valid[ch] = 1; smp_code[ch*CW +: CW] = code;
        @(negedge clk);
        smp_valid = '0;
    endtask

    // clear write and sample in the same cycle
    task automatic clr_and_sample(input logic [31:0] d, input int ch, input logic [CW-1:0] code);
        @(negedge clk);
        wr_en = 1; wr_addr = 8'h48; wr_data = d;
        smp_valid[ch] = 1; smp_code[ch*CW +: CW] = code;
        @(negedge clk);
        wr_en = 0; smp_valid = '0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        expect_rd("R1 status", 8'h48, 32'h0, 0);
        expect_rd("R1 enable", 8'h44, 32'h0, 0);
        expect_rd("R1 alarm reg", 8'h50, 32'h0, 0);
        expect_rd("R1 shut reg", 8'h64, 32'h0, 0);
        // R9 field placement and masking
        reg_wr(8'h50, 32'hF600_F700);
        expect_rd("R9 alarm0 fields", 8'h50, 32'h0600_0700, 0);
        reg_wr(8'h60, 32'h0400_0000);
        expect_rd("R9 shut0 field", 8'h60, 32'h0400_0000, 0);
        reg_wr(8'h54, 32'h0500_0550);
        expect_rd("R9 alarm1 fields", 8'h54, 32'h0500_0550, 0);
        // R5 data flag only
        sample(0, 12'h800);
        expect_rd("R5 data flag", 8'h48, 32'h100, 0);
        reg_wr(8'h48, 32'h100);
        expect_rd("R6 clear", 8'h48, 32'h0, 0);
        // R2 alarm at equality
        sample(0, 12'h600);
        expect_rd("R2 alarm at hot", 8'h48, 32'h101, 0);
        reg_wr(8'h48, 32'h101);
        // R3 no re-alarm while hot
        sample(0, 12'h5FF);
        expect_rd("R3 no rearm while hot", 8'h48, 32'h100, 0);
        reg_wr(8'h48, 32'h100);
        sample(0, 12'h700);
        sample(0, 12'h5F0);
        expect_rd("R3 release code keeps hot", 8'h48, 32'h100, 0);
        reg_wr(8'h48, 32'h100);
        sample(0, 12'h701);
        expect_rd("R3 release sample", 8'h48, 32'h100, 0);
        reg_wr(8'h48, 32'h100);
        sample(0, 12'h600);
        expect_rd("R3 rearm after release", 8'h48, 32'h101, 0);
        reg_wr(8'h48, 32'h101);
        // R4 shutdown, in hot state
        sample(0, 12'h400);
        expect_rd("R4 shut at limit while hot", 8'h48, 32'h110, 0);
        reg_wr(8'h48, 32'h110);
        sample(0, 12'h3FF);
        expect_rd("R4 shut repeats", 8'h48, 32'h110, 0);
        reg_wr(8'h48, 32'h110);
        // R6 partial clear
        sample(1, 12'h500);
        expect_rd("R2 alarm ch1", 8'h48, 32'h202, 0);
        reg_wr(8'h48, 32'h002);
        expect_rd("R6 zero bits kept", 8'h48, 32'h200, 0);
        // R7 set beats clear
        clr_and_sample(32'h200, 1, 12'h900);
        expect_rd("R7 set wins", 8'h48, 32'h200, 0);
        reg_wr(8'h48, 32'h200);
        expect_rd("R6 clear ch1", 8'h48, 32'h0, 0);
        // R8 interrupt masking
        reg_wr(8'h44, 32'h010);
        expect_rd("R8 enable readback", 8'h44, 32'h010, 0);
        sample(2, 12'h800);
        expect_rd("R8 unenabled flag", 8'h48, 32'h400, 0);
        sample(0, 12'h3FF);
        expect_rd("R8 enabled flag", 8'h48, 32'h510, 1);
        reg_wr(8'h48, 32'h010);
        expect_rd("R8 irq drops", 8'h48, 32'h500, 0);
        reg_wr(8'h44, 32'h400);
        expect_rd("R8 other enable", 8'h48, 32'h500, 1);
        reg_wr(8'h48, 32'h500);
        expect_rd("R8 all cleared", 8'h48, 32'h0, 0);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule